// File: doc/BRIEF.md
# Disc Controller Idle-State Sequencer

This block tracks which waiting condition a disc controller sits in between operations. There are three idle conditions. Which one the block enters depends on the kind of operation that has just finished. Each condition sets its own rules for answering a bus parallel poll, for reporting an unloaded drive and for accepting the rear-panel self-test switch. One of them also drives an unsolicited parallel poll response.

A separate busy state covers command execution. A self-test-pending state covers the time between a self-test trigger and the end of that test. Several events start a self test: reset, a power-on pulse, the drive becoming loaded, or an accepted switch press. The block only announces an accepted switch press, with a one-cycle start pulse. The self test and the command engine are external to the block.

Top module: `disc_idle_seq`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `idle_state` reads 3'd4 (self-test pending), and `poll_en`, `poll_resp`, `unload_rpt` and `st_start` are all 0.
- R2: In the pending state (3'd4), the state stays put until `selftest_done` is sampled high, and the following cycle it becomes 3'd3. `op_start` has no effect while pending. A `power_on` pulse in any state makes the next state 3'd4, and this takes priority over every other input.
- R3: In an idle state (3'd1, 3'd2 or 3'd3), `op_start` moves the block to busy (3'd0) on the next cycle. In busy, `op_done` with `op_kind` = 0 (ordinary secondary, whether it ended normally or with an error) enters 3'd1. Outside busy, `op_done` has no effect.
- R4: In busy, `op_done` with `op_kind` = 1 (END) or 2 (return-status-byte) enters 3'd2.
- R5: In busy, `op_done` with `op_kind` = 3 (hard clear) enters 3'd3.
- R6: In state 3'd1, `poll_en` = 1 and `unload_rpt` = 0 and `poll_resp` = 0, whatever the value of `drive_loaded`.
- R7: In state 3'd2, `poll_en` and `unload_rpt` both equal the inverse of `drive_loaded`, and `poll_resp` = 0.
- R8: In state 3'd3, `poll_en` and `unload_rpt` follow the same rule as in 3'd2, and `poll_resp` = 1.
- R9: A rising edge of `st_switch` produces exactly one `st_start` pulse when the block is in 3'd2 or 3'd3. The pulse is high for one cycle and appears SYNC_STAGES+1 rising clock edges after the switch changes; on that same edge the state becomes 3'd4. A rising edge in any other state is consumed without a pulse. Holding the switch high never produces a second pulse.
- R10: A rising edge of `drive_loaded` in an idle state makes the next state 3'd4, but `op_start` in the same cycle wins and the state becomes busy instead. In busy or pending, a loaded edge has no effect, and it is not remembered for later.
- R11: In busy (3'd0) and pending (3'd4), `poll_en`, `poll_resp` and `unload_rpt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse: a command or secondary begins |
| op_done | input | 1 | Pulse: the running operation has finished |
| op_kind | input | 2 | Kind of the finished operation: 0 secondary, 1 END, 2 status byte, 3 hard clear |
| selftest_done | input | 1 | Pulse: self test complete |
| power_on | input | 1 | Pulse: power-on event, forces a new self test |
| drive_loaded | input | 1 | Level: drive is loaded |
| st_switch | input | 1 | Asynchronous rear-panel self-test switch |
| idle_state | output | 3 | 0 busy, 1/2/3 idle states, 4 self-test pending |
| poll_en | output | 1 | Block answers a parallel poll |
| poll_resp | output | 1 | Unsolicited parallel poll response |
| unload_rpt | output | 1 | Unloaded drive is being reported |
| st_start | output | 1 | One-cycle self-test start request |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This makes the switch latency long enough that a sample taken one edge too early still shows the old idle state and no pulse. It therefore checks the exact edge in R9, and not only the arrival of the pulse. The same deeper synchronizer lets the bench hold the switch high across several state changes. This shows that an edge consumed in state 1, or one already taken, does not come back later as a pulse.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_BUSY  = 3'd0,
        ST_IDLE1 = 3'd1,
        ST_IDLE2 = 3'd2,
        ST_IDLE3 = 3'd3,
        ST_PEND  = 3'd4
    } idle_state_e;

    typedef enum logic [1:0] {
        OPK_SEC   = 2'd0,
        OPK_END   = 2'd1,
        OPK_DSJ   = 2'd2,
        OPK_CLEAR = 2'd3
    } op_kind_e;

    localparam int STATE_W = $bits(idle_state_e);
    localparam int KIND_W  = $bits(op_kind_e);

    typedef struct packed {
        idle_state_e state;
        logic        st_start;
        logic        load_prev;
    } seq_regs_t;

    function automatic logic is_idle(idle_state_e s);
        return (s == ST_IDLE1) || (s == ST_IDLE2) || (s == ST_IDLE3);
    endfunction

    function automatic logic switch_ok(idle_state_e s);
        return (s == ST_IDLE2) || (s == ST_IDLE3);
    endfunction

endpackage

// File: rtl/idle_seq_sync.sv
module idle_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t cur_q, nxt_d;
    logic [STAGES-1:0] shift_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign shift_d[g] = async_in;
        end else begin : g_next
            assign shift_d[g] = cur_q.chain[g-1];
        end
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = shift_d;
        nxt_d.prev  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise = cur_q.chain[STAGES-1] & ~cur_q.prev;
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import idle_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [KIND_W-1:0] op_kind,
    input  logic              selftest_done,
    input  logic              power_on,
    input  logic              drive_loaded,
    input  logic              sw_rise,
    output idle_state_e       state,
    output logic              st_start
);
    seq_regs_t cur_q, nxt_d;
    logic      load_rise;

    assign load_rise = drive_loaded & ~cur_q.load_prev;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.st_start  = 1'b0;
        nxt_d.load_prev = drive_loaded;
        if (power_on) begin
            nxt_d.state = ST_PEND;
        end else begin
            case (cur_q.state)
                ST_PEND: begin
                    if (selftest_done) nxt_d.state = ST_IDLE3;
                end
                ST_BUSY: begin
                    if (op_done) begin
                        case (op_kind_e'(op_kind))
                            OPK_SEC:          nxt_d.state = ST_IDLE1;
                            OPK_END, OPK_DSJ: nxt_d.state = ST_IDLE2;
                            OPK_CLEAR:        nxt_d.state = ST_IDLE3;
                            default:          nxt_d.state = ST_IDLE1;
                        endcase
                    end
                end
                default: begin
                    if (op_start) begin
                        nxt_d.state = ST_BUSY;
                    end else if (load_rise) begin
                        nxt_d.state = ST_PEND;
                    end else if (sw_rise && switch_ok(cur_q.state)) begin
                        nxt_d.state    = ST_PEND;
                        nxt_d.st_start = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state     <= ST_PEND;
            cur_q.st_start  <= 1'b0;
            cur_q.load_prev <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state    = cur_q.state;
    assign st_start = cur_q.st_start;
endmodule

// File: rtl/idle_seq_decode.sv
module idle_seq_decode
    import idle_seq_pkg::*;
(
    input  idle_state_e state,
    input  logic        drive_loaded,
    output logic        poll_en,
    output logic        poll_resp,
    output logic        unload_rpt
);
    always_comb begin
        poll_en    = 1'b0;
        poll_resp  = 1'b0;
        unload_rpt = 1'b0;
        case (state)
            ST_IDLE1: poll_en = 1'b1;
            ST_IDLE2: begin
                poll_en    = ~drive_loaded;
                unload_rpt = ~drive_loaded;
            end
            ST_IDLE3: begin
                poll_en    = ~drive_loaded;
                unload_rpt = ~drive_loaded;
                poll_resp  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/disc_idle_seq.sv
module disc_idle_seq
    import idle_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start,
    input  logic               op_done,
    input  logic [KIND_W-1:0]  op_kind,
    input  logic               selftest_done,
    input  logic               power_on,
    input  logic               drive_loaded,
    input  logic               st_switch,
    output logic [STATE_W-1:0] idle_state,
    output logic               poll_en,
    output logic               poll_resp,
    output logic               unload_rpt,
    output logic               st_start
);
    logic        sw_rise;
    idle_state_e state;

    idle_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (st_switch),
        .rise     (sw_rise)
    );

    idle_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_start      (op_start),
        .op_done       (op_done),
        .op_kind       (op_kind),
        .selftest_done (selftest_done),
        .power_on      (power_on),
        .drive_loaded  (drive_loaded),
        .sw_rise       (sw_rise),
        .state         (state),
        .st_start      (st_start)
    );

    idle_seq_decode u_dec (
        .state        (state),
        .drive_loaded (drive_loaded),
        .poll_en      (poll_en),
        .poll_resp    (poll_resp),
        .unload_rpt   (unload_rpt)
    );

    assign idle_state = state;
endmodule

// File: rtl/idle_seq_chk.sv
module idle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic       op_done,
    input logic [1:0] op_kind,
    input logic       selftest_done,
    input logic       power_on,
    input logic [2:0] idle_state,
    input logic       poll_en,
    input logic       poll_resp,
    input logic       unload_rpt,
    input logic       st_start
);
    logic in_idle;
    assign in_idle = (idle_state == 3'd1) || (idle_state == 3'd2) || (idle_state == 3'd3);

    assert_selftest_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd4 && selftest_done && !power_on) |=> idle_state == 3'd3);

    assert_power_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        power_on |=> idle_state == 3'd4);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && op_start && !power_on) |=> idle_state == 3'd0);

    assert_plain_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd0 && op_done && op_kind == 2'd0 && !power_on) |=> idle_state == 3'd1);

    assert_end_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd0 && op_done && (op_kind == 2'd1 || op_kind == 2'd2) && !power_on)
        |=> idle_state == 3'd2);

    assert_hard_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd0 && op_done && op_kind == 2'd3 && !power_on) |=> idle_state == 3'd3);

    assert_idle1_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd1) |-> (poll_en && !unload_rpt && !poll_resp));

    assert_pulse_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |-> ($past(idle_state) == 3'd2 || $past(idle_state) == 3'd3) && idle_state == 3'd4);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |=> !st_start);

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == 3'd0 || idle_state == 3'd4) |-> !(poll_en || poll_resp || unload_rpt));
endmodule

bind disc_idle_seq idle_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_start      (op_start),
    .op_done       (op_done),
    .op_kind       (op_kind),
    .selftest_done (selftest_done),
    .power_on      (power_on),
    .idle_state    (idle_state),
    .poll_en       (poll_en),
    .poll_resp     (poll_resp),
    .unload_rpt    (unload_rpt),
    .st_start      (st_start)
);

// File: tb/tb_disc_idle_seq.sv
`timescale 1ns/1ps
module tb_disc_idle_seq;
    localparam int SYNC = 3;
    localparam logic [2:0] S_BUSY = 3'd0, S_I1 = 3'd1, S_I2 = 3'd2, S_I3 = 3'd3, S_PEND = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_done = 0, selftest_done = 0, power_on = 0;
    logic drive_loaded = 1'b1, st_switch = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [2:0] idle_state;
    logic poll_en, poll_resp, unload_rpt, st_start;

    always #4 clk = ~clk;

    disc_idle_seq #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
        .op_kind(op_kind), .selftest_done(selftest_done), .power_on(power_on),
        .drive_loaded(drive_loaded), .st_switch(st_switch), .idle_state(idle_state),
        .poll_en(poll_en), .poll_resp(poll_resp), .unload_rpt(unload_rpt),
        .st_start(st_start)
    );

    typedef struct {
        string      req;
        logic [2:0] st;
        logic       pe, pr, ur;
        int         np;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, errors = 0, pulses = 0;
    bit finished = 0;

    // Monitor: counts start pulses and compares against queued expectations.
    always @(negedge clk) begin
        if (rst_n && st_start === 1'b1) pulses++;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (idle_state !== e.st || poll_en !== e.pe || poll_resp !== e.pr ||
                unload_rpt !== e.ur || pulses != e.np || st_start !== 1'b0 && e.np == 0) begin
                errors++;
                $display("FAIL %s: state=%0d/%0d poll_en=%0b/%0b resp=%0b/%0b unload=%0b/%0b pulses=%0d/%0d",
                         e.req, idle_state, e.st, poll_en, e.pe, poll_resp, e.pr,
                         unload_rpt, e.ur, pulses, e.np);
            end
            pulses = 0;
        end
    end

    task automatic expect_(string r, logic [2:0] s, logic pe, logic pr, logic ur, int np);
        exp_t e;
        e.req = r; e.st = s; e.pe = pe; e.pr = pr; e.ur = ur; e.np = np;
        exp_q.push_back(e);
    endtask

    task automatic adv(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1 op_start = 1;
        @(posedge clk); #1 op_start = 0;
    endtask

    task automatic pulse_done(logic [1:0] k);
        @(negedge clk); #1 op_done = 1; op_kind = k;
        @(posedge clk); #1 op_done = 0;
    endtask

    task automatic pulse_st_done();
        @(negedge clk); #1 selftest_done = 1;
        @(posedge clk); #1 selftest_done = 0;
    endtask

    task automatic pulse_pwr();
        @(negedge clk); #1 power_on = 1;
        @(posedge clk); #1 power_on = 0;
    endtask

    task automatic set_load(logic v);
        @(negedge clk); #1 drive_loaded = v;
        @(posedge clk); #1;
    endtask

    task automatic set_sw(logic v);
        @(negedge clk); #1 st_switch = v;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1;
        adv(1);
        expect_("R1 reset state", S_PEND, 0, 0, 0, 0);

        pulse_st_done();  expect_("R2 selftest done to idle3", S_I3, 0, 1, 0, 0);
        set_load(0);      expect_("R8 idle3 unloaded", S_I3, 1, 1, 1, 0);
        pulse_start();    expect_("R3 R11 busy quiet", S_BUSY, 0, 0, 0, 0);
        pulse_done(2'd0); expect_("R3 R6 secondary to idle1", S_I1, 1, 0, 0, 0);
        set_load(1);      expect_("R10 load edge in idle1", S_PEND, 0, 0, 0, 0);
        pulse_st_done();  expect_("R8 idle3 loaded", S_I3, 0, 1, 0, 0);
        pulse_start();
        pulse_done(2'd1); expect_("R4 R7 END to idle2", S_I2, 0, 0, 0, 0);
        set_load(0);      expect_("R7 idle2 unloaded", S_I2, 1, 0, 1, 0);
        pulse_start();
        pulse_done(2'd2); expect_("R4 status byte to idle2", S_I2, 1, 0, 1, 0);
        set_load(1);      expect_("R10 load edge in idle2", S_PEND, 0, 0, 0, 0);
        pulse_st_done();
        pulse_start();
        pulse_done(2'd1); expect_("R4 back to idle2", S_I2, 0, 0, 0, 0);

        set_sw(1);
        adv(SYNC);        expect_("R9 no pulse before latency", S_I2, 0, 0, 0, 0);
        adv(1);           expect_("R9 pulse in idle2", S_PEND, 0, 0, 0, 1);
        pulse_st_done();  expect_("R2 selftest after switch", S_I3, 0, 1, 0, 0);
        adv(6);           expect_("R9 held switch no repeat", S_I3, 0, 1, 0, 0);
        set_sw(0);
        adv(5);
        pulse_start();
        pulse_done(2'd0); expect_("R3 idle1 loaded", S_I1, 1, 0, 0, 0);
        set_sw(1);
        adv(6);           expect_("R9 switch ignored in idle1", S_I1, 1, 0, 0, 0);
        pulse_start();
        pulse_done(2'd3); expect_("R5 hard clear to idle3", S_I3, 0, 1, 0, 0);
        adv(4);           expect_("R9 consumed edge stays gone", S_I3, 0, 1, 0, 0);
        set_sw(0);
        adv(5);
        set_sw(1);
        adv(SYNC);        expect_("R9 idle3 before latency", S_I3, 0, 1, 0, 0);
        adv(1);           expect_("R9 pulse in idle3", S_PEND, 0, 0, 0, 1);
        set_sw(0);
        pulse_st_done();
        set_load(0);      expect_("R8 idle3 unloaded again", S_I3, 1, 1, 1, 0);

        @(negedge clk); #1 op_start = 1; drive_loaded = 1;
        @(posedge clk); #1 op_start = 0;
        expect_("R10 start beats load edge", S_BUSY, 0, 0, 0, 0);
        pulse_done(2'd0); expect_("R10 idle1 after priority", S_I1, 1, 0, 0, 0);
        adv(1);           expect_("R10 load edge not kept", S_I1, 1, 0, 0, 0);
        pulse_done(2'd1); expect_("R3 done ignored outside busy", S_I1, 1, 0, 0, 0);

        pulse_start();
        set_load(0);
        set_load(1);      expect_("R10 load edge ignored in busy", S_BUSY, 0, 0, 0, 0);
        pulse_done(2'd0); expect_("R10 busy exit idle1", S_I1, 1, 0, 0, 0);

        pulse_pwr();      expect_("R2 power-on from idle1", S_PEND, 0, 0, 0, 0);
        pulse_start();    expect_("R2 start ignored when pending", S_PEND, 0, 0, 0, 0);
        pulse_st_done();
        pulse_start();
        pulse_pwr();      expect_("R2 power-on from busy", S_PEND, 0, 0, 0, 0);
        pulse_st_done();  expect_("R2 selftest done again", S_I3, 0, 1, 0, 0);

        adv(3);
        finished = 1;
        summary();
        $finish;
    end
endmodule